// File: doc/BRIEF.md
# Bus Hold Request Handshake Controller

This block is the bus-ownership part of a processor bus interface unit. The unit runs bus cycles made of a fixed number of T-states, four by default, and sits in an idle state when the core has nothing to transfer. A second bus master can ask for the bus on a hold request line. The controller decides at which cycle boundary the bus is handed over, turns off its own address, data and control drivers while the other master owns the bus, and raises an acknowledge on the falling clock edge so the requester sees it half a clock after the decision.

A bus cycle already under way always runs to its last T-state. A request seen on any rising edge of a running cycle is remembered, even if it is withdrawn before the end of that cycle, and the bus is released after the last T-state. When the requester drops its line, the acknowledge falls on the next falling edge. The drivers come back one clock later, and only after that can a new bus cycle start. A core request that arrives while the bus is given away is kept pending and is served first.

Top module: `bus_hold_ctrl`

## Requirements
- R1: A synchronous reset, taken on the rising edge, sets `bus_state` to 0 (idle) and `bus_en` to 1. It clears `hold_ack` on the next falling edge, including when reset is applied while the bus is given away.
- R2: When `cyc_req` is seen high on a rising edge in idle (state 0), with `hold_req` low, `bus_state` steps through 1, 2, 3, 4 (T1 to T4) on successive rising edges. A started cycle is never cut short.
- R3: If `hold_req` is high on any rising edge that ends T1, T2, T3 or T4, the cycle still completes T4, and the edge that ends T4 moves the state to 5 (held). This also holds when `hold_req` has already dropped by then. No new T1 starts.
- R4: `hold_req` seen high on a rising edge in idle moves the state to 5 on that edge, without running any bus cycle.
- R5: `hold_ack` stays low at the rising edge that enters state 5. It goes high on the following falling edge.
- R6: `bus_en` is 0 in state 5 and in state 6 (return). Whenever `hold_ack` is high, `bus_en` is 0.
- R7: `hold_req` seen low on a rising edge in state 5 moves the state to 6. `hold_ack` falls on the next falling edge. The edge after that sets the state to 0 with `bus_en` equal to 1.
- R8: A `cyc_req` seen while the bus is held is kept pending. The state goes to 1 on the rising edge that follows the return to idle with drivers enabled.
- R9: In idle, a `hold_req` and a `cyc_req` on the same edge give the bus away first (state 5). The core request stays pending.
- R10: With `cyc_req` high and `hold_req` low through a cycle, the edge that ends T4 goes directly to T1 (state 1), with no idle state between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Rising edge for the state, falling edge for the acknowledge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Bus request from another master, active high |
| cyc_req | input | 1 | Request from the core to run a bus cycle |
| bus_state | output | ST_W | 0 idle, 1..T_COUNT T-states, T_COUNT+1 held, T_COUNT+2 return |
| bus_en | output | 1 | Enable for this unit's address, data and control drivers |
| hold_ack | output | 1 | Acknowledge to the requesting master |

## Verification
The main sweep starts a bus cycle and raises the hold request before each of the four cycle-ending edges, holding it for one to four clocks. A short pulse that is gone before T4 shows that the request is latched. A long one shows that the held state lasts until the line is sampled low. Every case runs with and without a core request during the hold, so a served pending cycle can be told apart from a lost one. Separate patterns cover the idle grant with and without a competing core request, back-to-back cycles, and reset applied while the bus is held. In all of them the acknowledge is read on both sides of the falling edge.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

   // coarse role of a bus_state code
   typedef enum logic [1:0] {
      K_IDLE,
      K_BUS,
      K_HELD,
      K_BACK
   } kind_e;

   function automatic kind_e kind_of(input int unsigned code, input int unsigned tcnt);
      if (code == 0)
         return K_IDLE;
      else if (code <= tcnt)
         return K_BUS;
      else if (code == tcnt + 1)
         return K_HELD;
      else
         return K_BACK;
   endfunction

endpackage

// File: rtl/bhc_hold_track.sv
// Remembers a hold request seen on any edge of a running bus cycle.
module bhc_hold_track (
   input  logic clk,
   input  logic rst,
   input  logic in_bus,
   input  logic at_last,
   input  logic hold_req,
   output logic grant_due
);

   logic seen_q;

   always_ff @(posedge clk) begin
      if (rst || !in_bus || at_last)
         seen_q <= 1'b0;
      else if (hold_req)
         seen_q <= 1'b1;
   end

   assign grant_due = seen_q | hold_req;

endmodule

// File: rtl/bhc_seq.sv
// T-state sequencer with pending core request and driver enable.
module bhc_seq
   import bhc_pkg::*;
#(
   parameter int T_COUNT = 4,
   parameter int ST_W    = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold_req,
   input  logic            cyc_req,
   input  logic            grant_due,
   output logic [ST_W-1:0] state_q,
   output logic            bus_en_q,
   output logic            in_bus,
   output logic            at_last,
   output logic            in_held
);

   localparam logic [ST_W-1:0] S_IDLE  = '0;
   localparam logic [ST_W-1:0] S_FIRST = ST_W'(1);
   localparam logic [ST_W-1:0] S_LAST  = ST_W'(T_COUNT);
   localparam logic [ST_W-1:0] S_HELD  = ST_W'(T_COUNT + 1);
   localparam logic [ST_W-1:0] S_BACK  = ST_W'(T_COUNT + 2);

   kind_e           kind;
   logic [ST_W-1:0] state_d;
   logic            pend_q;
   logic            pend_d;
   logic            want;

   assign kind    = kind_of(int'(state_q), T_COUNT);
   assign in_bus  = (kind == K_BUS);
   assign in_held = (kind == K_HELD);
   assign at_last = (state_q == S_LAST);
   assign want    = cyc_req | pend_q;

   always_comb begin
      state_d = state_q;
      unique case (kind)
         K_IDLE: begin
            if (hold_req)
               state_d = S_HELD;
            else if (want)
               state_d = S_FIRST;
            else
               state_d = S_IDLE;
         end
         K_BUS: begin
            if (!at_last)
               state_d = state_q + S_FIRST;
            else if (grant_due)
               state_d = S_HELD;
            else if (want)
               state_d = S_FIRST;
            else
               state_d = S_IDLE;
         end
         K_HELD:  state_d = hold_req ? S_HELD : S_BACK;
         K_BACK:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   assign pend_d = (state_d == S_FIRST) ? 1'b0 : (pend_q | cyc_req);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= S_IDLE;
         pend_q   <= 1'b0;
         bus_en_q <= 1'b1;
      end else begin
         state_q  <= state_d;
         pend_q   <= pend_d;
         bus_en_q <= !((state_d == S_HELD) || (state_d == S_BACK));
      end
   end

endmodule

// File: rtl/bhc_ack.sv
// Acknowledge register; the parameter picks the clock edge it updates on.
module bhc_ack #(
   parameter bit ACK_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic in_held,
   output logic ack_q
);

   generate
      if (ACK_ON_FALL) begin : g_fall
         always_ff @(negedge clk) begin
            if (rst) ack_q <= 1'b0;
            else     ack_q <= in_held;
         end
      end else begin : g_rise
         always_ff @(posedge clk) begin
            if (rst) ack_q <= 1'b0;
            else     ack_q <= in_held;
         end
      end
   endgenerate

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
   parameter int T_COUNT     = 4,
   parameter bit ACK_ON_FALL = 1'b1,
   localparam int ST_W       = $clog2(T_COUNT + 3)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold_req,
   input  logic            cyc_req,
   output logic [ST_W-1:0] bus_state,
   output logic            bus_en,
   output logic            hold_ack
);

   generate
      if (T_COUNT < 2) begin : g_bad_tcount
         $error("bus_hold_ctrl: T_COUNT must be at least 2");
      end
   endgenerate

   logic in_bus;
   logic at_last;
   logic in_held;
   logic grant_due;

   bhc_hold_track u_track (
      .clk       (clk),
      .rst       (rst),
      .in_bus    (in_bus),
      .at_last   (at_last),
      .hold_req  (hold_req),
      .grant_due (grant_due)
   );

   bhc_seq #(
      .T_COUNT (T_COUNT),
      .ST_W    (ST_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .hold_req  (hold_req),
      .cyc_req   (cyc_req),
      .grant_due (grant_due),
      .state_q   (bus_state),
      .bus_en_q  (bus_en),
      .in_bus    (in_bus),
      .at_last   (at_last),
      .in_held   (in_held)
   );

   bhc_ack #(
      .ACK_ON_FALL (ACK_ON_FALL)
   ) u_ack (
      .clk     (clk),
      .rst     (rst),
      .in_held (in_held),
      .ack_q   (hold_ack)
   );

endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk #(
   parameter int T_COUNT = 4,
   parameter int ST_W    = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            hold_req,
   input logic [ST_W-1:0] bus_state,
   input logic            bus_en,
   input logic            hold_ack
);

   localparam logic [ST_W-1:0] C_IDLE = '0;
   localparam logic [ST_W-1:0] C_ONE  = ST_W'(1);
   localparam logic [ST_W-1:0] C_LAST = ST_W'(T_COUNT);
   localparam logic [ST_W-1:0] C_HELD = ST_W'(T_COUNT + 1);
   localparam logic [ST_W-1:0] C_BACK = ST_W'(T_COUNT + 2);

   // R2: a started cycle advances one T-state per clock
   assert_cycle_steps_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_state >= C_ONE && bus_state < C_LAST) |=> bus_state == $past(bus_state) + C_ONE);

   // R3: the held state is only entered from idle or from the last T-state
   assert_grant_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_state == C_HELD && $past(bus_state) != C_HELD)
         |-> ($past(bus_state) == C_IDLE || $past(bus_state) == C_LAST));

   // R4: idle grant is immediate
   assert_idle_grant_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_state == C_IDLE && hold_req) |=> bus_state == C_HELD);

   // R5: no acknowledge without the held state in the last two clocks
   assert_ack_needs_held_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_state != C_HELD && $past(bus_state) != C_HELD) |-> !hold_ack);

   // R6: acknowledge implies floated drivers
   assert_float_when_ack_R6: assert property (@(posedge clk) disable iff (rst)
      hold_ack |-> !bus_en);

   // R7: return state lasts one clock and re-enables drivers
   assert_return_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_state == C_BACK) |=> (bus_state == C_IDLE && bus_en));

endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk #(
   .T_COUNT (T_COUNT),
   .ST_W    (ST_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .hold_req  (hold_req),
   .bus_state (bus_state),
   .bus_en    (bus_en),
   .hold_ack  (hold_ack)
);

// File: tb/bus_hold_ctrl_bench.sv
module bus_hold_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ST_HELD    = 5;
   localparam int ST_BACK    = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       hold_req = 1'b0;
   logic       cyc_req = 1'b0;
   logic [2:0] bus_state;
   logic       bus_en;
   logic       hold_ack;

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;

   bus_hold_ctrl u_bus_hold_ctrl (
      .clk       (clk),
      .rst       (rst),
      .hold_req  (hold_req),
      .cyc_req   (cyc_req),
      .bus_state (bus_state),
      .bus_en    (bus_en),
      .hold_ack  (hold_ack)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic half();
      @(negedge clk);
      #1;
   endtask

   // hold raised for edges p..p+d-1 of a cycle started at edge 0
   task automatic run_case(input int p, input int d, input bit pend);
      int m;
      int exp;
      int prev_held;
      m = (p + d > 5) ? p + d : 5;
      prev_held = 0;
      cyc_req  = 1'b1;
      hold_req = 1'b0;
      tick();
      chk("R2 first T-state", int'(bus_state), 1);
      half();
      for (int i = 1; i <= m + 2; i++) begin
         hold_req = (i >= p && i <= p + d - 1);
         cyc_req  = pend && (i == 5);
         tick();
         if (i < 4)           exp = i + 1;
         else if (i < m)      exp = ST_HELD;
         else if (i == m)     exp = ST_BACK;
         else if (i == m + 1) exp = 0;
         else                 exp = pend ? 1 : 0;
         if (i < 4)           chk("R2 T-state step", int'(bus_state), exp);
         else if (i < m)      chk("R3 held after cycle end", int'(bus_state), exp);
         else if (i <= m + 1) chk("R7 return sequence", int'(bus_state), exp);
         else                 chk("R8 pending request served", int'(bus_state), exp);
         chk("R6 driver enable", int'(bus_en), (exp == ST_HELD || exp == ST_BACK) ? 0 : 1);
         chk("R5 ack before falling edge", int'(hold_ack), prev_held);
         half();
         chk("R5 ack after falling edge", int'(hold_ack), (exp == ST_HELD) ? 1 : 0);
         prev_held = (exp == ST_HELD) ? 1 : 0;
      end
      hold_req = 1'b0;
      cyc_req  = 1'b0;
      repeat (6) tick();
      chk("R2 settle to idle", int'(bus_state), 0);
      half();
   endtask

   initial begin
      // R1 reset state
      tick();
      tick();
      chk("R1 reset state", int'(bus_state), 0);
      chk("R1 reset bus_en", int'(bus_en), 1);
      half();
      chk("R1 reset ack", int'(hold_ack), 0);
      rst = 1'b0;
      tick();
      chk("R1 stays idle", int'(bus_state), 0);
      half();

      // main sweep: phase, length, pending request
      for (int p = 1; p <= 4; p++)
         for (int d = 1; d <= 4; d++)
            for (int k = 0; k < 2; k++)
               run_case(p, d, k[0]);

      // R4 / R9: idle grant beats a core request
      hold_req = 1'b1;
      cyc_req  = 1'b1;
      tick();
      chk("R4 R9 idle grant", int'(bus_state), ST_HELD);
      chk("R6 float in idle grant", int'(bus_en), 0);
      chk("R5 no ack at grant edge", int'(hold_ack), 0);
      half();
      chk("R5 ack on falling edge", int'(hold_ack), 1);
      cyc_req = 1'b0;
      tick();
      chk("R4 still held", int'(bus_state), ST_HELD);
      half();
      hold_req = 1'b0;
      tick();
      chk("R7 return state", int'(bus_state), ST_BACK);
      chk("R7 drivers still off", int'(bus_en), 0);
      chk("R7 ack before fall", int'(hold_ack), 1);
      half();
      chk("R7 ack falls", int'(hold_ack), 0);
      tick();
      chk("R7 idle again", int'(bus_state), 0);
      chk("R7 drivers on", int'(bus_en), 1);
      half();
      tick();
      chk("R9 pending cycle starts", int'(bus_state), 1);
      half();
      repeat (3) tick();
      chk("R2 cycle ends at T4", int'(bus_state), 4);
      tick();
      chk("R2 idle after cycle", int'(bus_state), 0);
      half();

      // R10 back-to-back cycles
      cyc_req = 1'b1;
      tick();
      chk("R10 T1", int'(bus_state), 1);
      half();
      for (int t = 2; t <= 4; t++) begin
         tick();
         chk("R10 T-step", int'(bus_state), t);
      end
      tick();
      chk("R10 direct T1 after T4", int'(bus_state), 1);
      chk("R10 drivers kept", int'(bus_en), 1);
      cyc_req = 1'b0;
      half();
      repeat (3) tick();
      chk("R10 second cycle T4", int'(bus_state), 4);
      tick();
      chk("R10 idle after", int'(bus_state), 0);
      half();

      // R1 reset while the bus is held
      hold_req = 1'b1;
      tick();
      chk("R4 held before reset", int'(bus_state), ST_HELD);
      half();
      chk("R5 ack before reset", int'(hold_ack), 1);
      rst = 1'b1;
      tick();
      chk("R1 reset from held state", int'(bus_state), 0);
      chk("R1 reset enables drivers", int'(bus_en), 1);
      half();
      chk("R1 reset clears ack", int'(hold_ack), 0);
      rst      = 1'b0;
      hold_req = 1'b0;
      tick();
      chk("R1 idle after reset", int'(bus_state), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule